// File: doc/BRIEF.md
# Three-Level Reference Sort and Clamping Offset Injector

This block sits in the reference path of a three-level converter modulator. On each valid sample it takes three signed fixed-point phase references, ranks them into largest, middle and smallest, and adds one common zero-sequence offset to all three. The offset is chosen so that exactly one phase sits on a fixed level for the whole carrier period. That level is neutral, the positive rail or the negative rail, and the choice depends on the region the reference vector occupies. The result is a discontinuous, clamped set of references, ready for carrier comparison further down the chain.

Sector and region detection happen upstream and arrive as inputs alongside the references. The block returns the three shifted references, the largest and smallest of them, and a tag. The tag names the clamped phase and the level it is held at. Results are registered one cycle after the input strobe.

Top module: `tlc_clamp_inject`

## Requirements
- R1: The three references are ranked by value. Equal values rank by phase position, with A above B and B above C. The phase picked as largest, middle or smallest is reported through `clamp_phase`, which is one-hot with bit0 = A, bit1 = B and bit2 = C.
- R2: When the sector is valid and region code is 0 or 1, the offset is the negated middle reference. The middle phase output becomes 0, and `clamp_level` = 2'b10 (neutral) with `clamp_phase` set to that phase.
- R3: When the sector is valid and region code is 2, the offset is +FS minus the largest reference, where FS = 2^(W-1)-1. The largest phase output becomes +FS, and `clamp_level` = 2'b01 (positive).
- R4: When the sector is valid and region code is 3, the offset is -FS minus the smallest reference. The smallest phase output becomes -FS, and `clamp_level` = 2'b11 (negative).
- R5: The same offset is added to all three phases. Each sum saturates to the range [-FS, +FS].
- R6: Sector codes 1 to 6 are valid. Codes 0 and 7 inject no offset, so the outputs are the inputs saturated to [-FS, +FS], with `clamp_phase` = 3'b000 and `clamp_level` = 2'b00.
- R7: `out_valid` goes high exactly one cycle after a cycle with `in_valid` high and is low otherwise. The data outputs and the tag update only on a valid sample and hold their values in between.
- R8: `out_max` and `out_min` equal the largest and smallest of `out_a`, `out_b` and `out_c`.
- R9: While reset is asserted, every output is 0 and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| sector | input | 3 | Sector code, 1 to 6 valid |
| region | input | 2 | Region code 0 to 3 within the sector |
| ref_a | input | W | Phase A reference, signed |
| ref_b | input | W | Phase B reference, signed |
| ref_c | input | W | Phase C reference, signed |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_a | output | W | Shifted phase A reference |
| out_b | output | W | Shifted phase B reference |
| out_c | output | W | Shifted phase C reference |
| out_max | output | W | Largest shifted reference |
| out_min | output | W | Smallest shifted reference |
| clamp_phase | output | 3 | One-hot clamped phase (bit0 A, bit1 B, bit2 C) |
| clamp_level | output | 2 | 00 none, 01 positive, 10 neutral, 11 negative |

## Verification
The first patterns are one fixed, well-spread triple driven through all four region codes. They separate the neutral, positive and negative offset choices and show which phase each one selects. Triples with two or three equal values show whether the tie order A over B over C is kept. Near-full-scale triples show whether each sum saturates on its own while the clamped phase still lands exactly on its rail. Sector codes 0 and 7 check that no offset is injected. Random triples, sectors and regions with idle gaps between samples check the ranking across all orderings, along with the one-cycle latency and the holding of outputs between samples.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  typedef enum logic [1:0] {
    LVL_NONE = 2'b00,
    LVL_POS  = 2'b01,
    LVL_NEU  = 2'b10,
    LVL_NEG  = 2'b11
  } clamp_lvl_e;

  localparam int unsigned NPH = 3;

  localparam logic [2:0] SECTOR_FIRST = 3'd1;
  localparam logic [2:0] SECTOR_LAST  = 3'd6;

endpackage

// File: rtl/tlc_sort.sv
module tlc_sort #(
  parameter int unsigned W = 16
) (
  input  logic signed [W-1:0] va,
  input  logic signed [W-1:0] vb,
  input  logic signed [W-1:0] vc,
  output logic signed [W-1:0] top_v,
  output logic signed [W-1:0] mid_v,
  output logic signed [W-1:0] bot_v,
  output logic [2:0]          top_oh,
  output logic [2:0]          mid_oh,
  output logic [2:0]          bot_oh
);

  logic a_ge_b;
  logic a_ge_c;
  logic b_ge_c;

  always_comb begin
    a_ge_b = (va >= vb);
    a_ge_c = (va >= vc);
    b_ge_c = (vb >= vc);
  end

  // Tie rule: an earlier phase ranks above a later one when values match.
  always_comb begin
    top_oh = {~a_ge_c & ~b_ge_c, ~a_ge_b & b_ge_c, a_ge_b & a_ge_c};
    bot_oh = {a_ge_c & b_ge_c, a_ge_b & ~b_ge_c, ~a_ge_b & ~a_ge_c};
    mid_oh = ~(top_oh | bot_oh);
  end

  function automatic logic signed [W-1:0] pick(
    input logic [2:0]          oh,
    input logic signed [W-1:0] x0,
    input logic signed [W-1:0] x1,
    input logic signed [W-1:0] x2
  );
    pick = ({W{oh[0]}} & x0) | ({W{oh[1]}} & x1) | ({W{oh[2]}} & x2);
  endfunction

  always_comb begin
    top_v = pick(top_oh, va, vb, vc);
    mid_v = pick(mid_oh, va, vb, vc);
    bot_v = pick(bot_oh, va, vb, vc);
  end

endmodule

// File: rtl/tlc_offset.sv
module tlc_offset
  import tlc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [2:0]          sector,
  input  logic [1:0]          region,
  input  logic signed [W-1:0] top_v,
  input  logic signed [W-1:0] mid_v,
  input  logic signed [W-1:0] bot_v,
  input  logic [2:0]          top_oh,
  input  logic [2:0]          mid_oh,
  input  logic [2:0]          bot_oh,
  output logic signed [W+1:0] offset,
  output logic [2:0]          clamp_oh,
  output clamp_lvl_e          clamp_lvl
);

  localparam int unsigned XW = W + 2;
  localparam logic signed [XW-1:0] RAIL_P = $signed({3'b000, {(W-1){1'b1}}});
  localparam logic signed [XW-1:0] RAIL_N = -RAIL_P;

  logic                 sector_ok;
  logic signed [XW-1:0] top_x;
  logic signed [XW-1:0] mid_x;
  logic signed [XW-1:0] bot_x;

  always_comb begin
    sector_ok = (sector >= SECTOR_FIRST) && (sector <= SECTOR_LAST);
    top_x = $signed({{2{top_v[W-1]}}, top_v});
    mid_x = $signed({{2{mid_v[W-1]}}, mid_v});
    bot_x = $signed({{2{bot_v[W-1]}}, bot_v});
  end

  always_comb begin
    offset    = '0;
    clamp_oh  = 3'b000;
    clamp_lvl = LVL_NONE;
    if (sector_ok) begin
      unique case (region)
        2'd0, 2'd1: begin
          offset    = -mid_x;
          clamp_oh  = mid_oh;
          clamp_lvl = LVL_NEU;
        end
        2'd2: begin
          offset    = RAIL_P - top_x;
          clamp_oh  = top_oh;
          clamp_lvl = LVL_POS;
        end
        default: begin
          offset    = RAIL_N - bot_x;
          clamp_oh  = bot_oh;
          clamp_lvl = LVL_NEG;
        end
      endcase
    end
  end

endmodule

// File: rtl/tlc_addsat.sv
module tlc_addsat #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 5
) (
  input  logic [N-1:0][W-1:0] vals,
  input  logic signed [W+1:0] offset,
  output logic [N-1:0][W-1:0] sums
);

  localparam int unsigned XW = W + 2;
  localparam logic signed [XW-1:0] RAIL_P = $signed({3'b000, {(W-1){1'b1}}});
  localparam logic signed [XW-1:0] RAIL_N = -RAIL_P;

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic signed [XW-1:0] raw;
    always_comb begin
      raw = $signed({{2{vals[i][W-1]}}, vals[i]}) + offset;
      if (raw > RAIL_P) begin
        sums[i] = RAIL_P[W-1:0];
      end else if (raw < RAIL_N) begin
        sums[i] = RAIL_N[W-1:0];
      end else begin
        sums[i] = raw[W-1:0];
      end
    end
  end

endmodule

// File: rtl/tlc_clamp_inject.sv
module tlc_clamp_inject
  import tlc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2:0]          sector,
  input  logic [1:0]          region,
  input  logic signed [W-1:0] ref_a,
  input  logic signed [W-1:0] ref_b,
  input  logic signed [W-1:0] ref_c,
  output logic                out_valid,
  output logic signed [W-1:0] out_a,
  output logic signed [W-1:0] out_b,
  output logic signed [W-1:0] out_c,
  output logic signed [W-1:0] out_max,
  output logic signed [W-1:0] out_min,
  output logic [2:0]          clamp_phase,
  output logic [1:0]          clamp_level
);

  localparam int unsigned LANES = NPH + 2;
  localparam logic signed [W-1:0] RAIL_P = $signed({1'b0, {(W-1){1'b1}}});
  localparam logic signed [W-1:0] RAIL_N = -RAIL_P;

  logic signed [W-1:0] top_v;
  logic signed [W-1:0] mid_v;
  logic signed [W-1:0] bot_v;
  logic [2:0]          top_oh;
  logic [2:0]          mid_oh;
  logic [2:0]          bot_oh;
  logic signed [W+1:0] offset;
  logic [2:0]          tag_oh;
  clamp_lvl_e          tag_lvl;
  logic [LANES-1:0][W-1:0] lane_in;
  logic [LANES-1:0][W-1:0] lane_out;

  tlc_sort #(.W(W)) u_sort (
    .va     (ref_a),
    .vb     (ref_b),
    .vc     (ref_c),
    .top_v  (top_v),
    .mid_v  (mid_v),
    .bot_v  (bot_v),
    .top_oh (top_oh),
    .mid_oh (mid_oh),
    .bot_oh (bot_oh)
  );

  tlc_offset #(.W(W)) u_offset (
    .sector    (sector),
    .region    (region),
    .top_v     (top_v),
    .mid_v     (mid_v),
    .bot_v     (bot_v),
    .top_oh    (top_oh),
    .mid_oh    (mid_oh),
    .bot_oh    (bot_oh),
    .offset    (offset),
    .clamp_oh  (tag_oh),
    .clamp_lvl (tag_lvl)
  );

  always_comb begin
    lane_in[0] = ref_a;
    lane_in[1] = ref_b;
    lane_in[2] = ref_c;
    lane_in[3] = top_v;
    lane_in[4] = bot_v;
  end

  tlc_addsat #(.W(W), .N(LANES)) u_addsat (
    .vals   (lane_in),
    .offset (offset),
    .sums   (lane_out)
  );

  logic                valid_d;
  logic signed [W-1:0] a_d, b_d, c_d, max_d, min_d;
  logic [2:0]          ph_d;
  logic [1:0]          lvl_d;

  always_comb begin
    valid_d = in_valid;
    a_d     = out_a;
    b_d     = out_b;
    c_d     = out_c;
    max_d   = out_max;
    min_d   = out_min;
    ph_d    = clamp_phase;
    lvl_d   = clamp_level;
    if (in_valid) begin
      a_d   = lane_out[0];
      b_d   = lane_out[1];
      c_d   = lane_out[2];
      max_d = lane_out[3];
      min_d = lane_out[4];
      ph_d  = tag_oh;
      lvl_d = tag_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_a       <= '0;
      out_b       <= '0;
      out_c       <= '0;
      out_max     <= '0;
      out_min     <= '0;
      clamp_phase <= '0;
      clamp_level <= '0;
    end else begin
      out_valid   <= valid_d;
      out_a       <= a_d;
      out_b       <= b_d;
      out_c       <= c_d;
      out_max     <= max_d;
      out_min     <= min_d;
      clamp_phase <= ph_d;
      clamp_level <= lvl_d;
    end
  end

  logic signed [W-1:0] clamped_out;
  always_comb begin
    clamped_out = clamp_phase[0] ? out_a : (clamp_phase[1] ? out_b : out_c);
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R7
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R7
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_a) && $stable(out_b) && $stable(out_c) && $stable(clamp_phase))); // R7
  AST_NEUTRAL_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && clamp_level == LVL_NEU) |-> (clamped_out == '0)); // R2
  AST_POS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && clamp_level == LVL_POS) |-> (clamped_out == RAIL_P)); // R3
  AST_NEG_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && clamp_level == LVL_NEG) |-> (clamped_out == RAIL_N)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_a >= RAIL_N && out_b >= RAIL_N && out_c >= RAIL_N)); // R5
  AST_TAG_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clamp_phase) && ((clamp_level == LVL_NONE) == (clamp_phase == 3'b000))); // R6
  AST_BAD_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (sector == 3'd0 || sector == 3'd7)) |=> (clamp_level == LVL_NONE)); // R6
  AST_EXTREMES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_max >= out_a && out_max >= out_b && out_max >= out_c &&
                   out_min <= out_a && out_min <= out_b && out_min <= out_c)); // R8

endmodule

// File: tb/tb_tlc_clamp_inject.sv
module tb_tlc_clamp_inject;

  localparam int W = 16;
  localparam int FS = 32767;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                in_valid;
  logic [2:0]          sector;
  logic [1:0]          region;
  logic signed [W-1:0] ref_a, ref_b, ref_c;
  logic                out_valid;
  logic signed [W-1:0] out_a, out_b, out_c, out_max, out_min;
  logic [2:0]          clamp_phase;
  logic [1:0]          clamp_level;

  always #10 clk = ~clk;

  tlc_clamp_inject #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sector(sector), .region(region),
    .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c), .out_valid(out_valid),
    .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_max(out_max), .out_min(out_min),
    .clamp_phase(clamp_phase), .clamp_level(clamp_level)
  );

  typedef struct {
    int         a, b, c, mx, mn;
    logic [2:0] ph;
    logic [1:0] lv;
    string      tag;
  } item_t;

  item_t q[$];
  item_t last;
  bit    have_last = 0;
  bit    started = 0;
  bit    done = 0;
  int    checks = 0;
  int    failures = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(input int x);
    if (x > FS) return FS;
    if (x < -FS) return -FS;
    return x;
  endfunction

  function automatic item_t model(input int va, input int vb, input int vc,
                                  input int sec, input int rg, input string tag);
    item_t it;
    int v[3];
    int rank[3];
    int hi, md, lo, off;
    int o[3];
    v[0] = va; v[1] = vb; v[2] = vc;
    hi = 0; md = 0; lo = 0;
    for (int i = 0; i < 3; i++) begin
      rank[i] = 0;
      for (int j = 0; j < 3; j++)
        if (j != i && (v[i] > v[j] || (v[i] == v[j] && i < j))) rank[i]++;
      if (rank[i] == 2) hi = i;
      if (rank[i] == 1) md = i;
      if (rank[i] == 0) lo = i;
    end
    off = 0; it.ph = 3'b000; it.lv = 2'b00;
    if (sec >= 1 && sec <= 6) begin
      if (rg < 2) begin off = -v[md]; it.ph = 3'(1 << md); it.lv = 2'b10; end
      else if (rg == 2) begin off = FS - v[hi]; it.ph = 3'(1 << hi); it.lv = 2'b01; end
      else begin off = -FS - v[lo]; it.ph = 3'(1 << lo); it.lv = 2'b11; end
    end
    for (int i = 0; i < 3; i++) o[i] = sat(v[i] + off);
    it.a = o[0]; it.b = o[1]; it.c = o[2];
    it.mx = o[0]; it.mn = o[0];
    for (int i = 1; i < 3; i++) begin
      if (o[i] > it.mx) it.mx = o[i];
      if (o[i] < it.mn) it.mn = o[i];
    end
    it.tag = tag;
    return it;
  endfunction

  task automatic drive(input int va, input int vb, input int vc,
                       input int sec, input int rg, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    ref_a = 16'(va); ref_b = 16'(vb); ref_c = 16'(vc);
    sector = 3'(sec); region = 2'(rg);
    q.push_back(model(va, vb, vc, sec, rg, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      ref_a = 16'h1234; ref_b = -16'sd777; ref_c = 16'h0101;
      sector = 3'd2; region = 2'd3;
    end
  endtask

  // Monitor: pops expected items as results appear.
  always @(negedge clk) begin
    if (started && rst_n) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          chk("R7", "unexpected out_valid", 1, 0);
        end else begin
          item_t e;
          e = q.pop_front();
          chk(e.tag, "out_a", int'(out_a), e.a);
          chk(e.tag, "out_b", int'(out_b), e.b);
          chk(e.tag, "out_c", int'(out_c), e.c);
          chk(e.tag, "clamp_phase", int'(clamp_phase), int'(e.ph));
          chk(e.tag, "clamp_level", int'(clamp_level), int'(e.lv));
          chk("R8", "out_max", int'(out_max), e.mx);
          chk("R8", "out_min", int'(out_min), e.mn);
          last = e;
          have_last = 1;
        end
      end else if (have_last) begin
        chk("R7", "hold out_a", int'(out_a), last.a);
        chk("R7", "hold clamp_phase", int'(clamp_phase), int'(last.ph));
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    ref_a = 16'sd5000; ref_b = 16'sd100; ref_c = -16'sd9000;
    sector = 3'd1; region = 2'd2;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "out_valid", int'(out_valid), 0);
    chk("R9", "out_a", int'(out_a), 0);
    chk("R9", "out_max", int'(out_max), 0);
    chk("R9", "clamp_phase", int'(clamp_phase), 0);
    chk("R9", "clamp_level", int'(clamp_level), 0);
    rst_n = 1'b1;
    @(negedge clk);
    started = 1;

    // R2 R3 R4: one spread triple through every region code
    drive(10000, 2000, -12000, 1, 0, "R2");
    drive(10000, 2000, -12000, 1, 1, "R2");
    drive(10000, 2000, -12000, 1, 2, "R3");
    drive(10000, 2000, -12000, 1, 3, "R4");
    // rotated phase ordering
    drive(-3000, 15000, 4000, 3, 0, "R2");
    drive(-3000, 15000, 4000, 4, 2, "R3");
    drive(-3000, 15000, 4000, 5, 3, "R4");
    idle(3);
    // R1: ties ranked A over B over C
    drive(5000, 5000, 5000, 2, 0, "R1");
    drive(5000, 5000, 5000, 2, 2, "R1");
    drive(5000, 5000, 5000, 2, 3, "R1");
    drive(-700, -700, 900, 6, 3, "R1");
    drive(300, 800, 800, 6, 2, "R1");
    drive(300, 800, 800, 6, 0, "R1");
    // R5: saturation of non-clamped phases
    drive(32767, -32768, 0, 1, 3, "R5");
    drive(-32768, 32767, 100, 2, 2, "R5");
    drive(32000, -32000, 31000, 1, 0, "R5");
    // R6: invalid sector codes
    drive(1200, -3400, 2200, 0, 2, "R6");
    drive(-32768, 32767, 5, 7, 3, "R6");
    idle(2);
    // random mix
    for (int n = 0; n < 400; n++) begin
      int ra, rb, rc;
      ra = int'($signed(16'($urandom)));
      rb = int'($signed(16'($urandom)));
      rc = int'($signed(16'($urandom)));
      if (($urandom % 5) == 0) rb = ra;
      drive(ra, rb, rc, int'($urandom % 8), int'($urandom % 4), "R5");
      if (($urandom % 3) == 0) idle(int'($urandom % 3) + 1);
    end
    idle(4);
    chk("R7", "queue drained", q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule